// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns a base address and an unsigned index byte into the effective address of an indexed memory access. It has one byte-wide adder and nothing wider. In the first cycle after a request it adds the index to the low byte of the base. For an absolute indexed access, a carry out of that sum means the adder is needed again. In that case the block spends one more cycle adding the carry into the high byte, and marks that cycle as a penalty cycle. Zero-page indexed accesses never use the high byte: the sum wraps inside page zero and is final after one cycle.

A sequencer presents a request on `req` together with the base, index, mode and direction. The request is taken when the block is idle. The sequencer then waits for `ea_valid`, which is high for exactly one cycle. `fix_cycle` tells the sequencer that this access cost the extra cycle. An absolute indexed write always takes the extra cycle, whether or not it crosses a page, so the write never reaches memory at an address whose high byte is not yet correct.

Top module: `idx_agu`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ea_valid`, `fix_cycle` and `busy` are low.
- R2: An absolute indexed read (`mode`=1, `is_wr`=0) whose low-byte sum stays below 256 gives `ea` = base + index with `ea_valid` high one cycle after acceptance and `fix_cycle` low.
- R3: An absolute indexed read whose low-byte sum reaches 256 gives `ea_valid` two cycles after acceptance, with `fix_cycle` high in that same cycle and `ea` = base + index. The low byte of `ea` equals the low-byte sum from the cycle before.
- R4: A zero-page indexed access (`mode`=0) gives `ea` = {8'h00, (base[7:0] + index) mod 256} one cycle after acceptance, for reads and writes alike. `fix_cycle` is never high and `base[15:8]` is ignored.
- R5: An absolute indexed write (`mode`=1, `is_wr`=1) always completes two cycles after acceptance with `fix_cycle` high, even when no page is crossed.
- R6: An absolute indexed address wraps modulo 65536 when the high-byte fix-up overflows.
- R7: `ea_valid` is high for exactly one cycle for each accepted request, and `fix_cycle` is high only in a cycle where `ea_valid` is high.
- R8: A request is accepted only while `busy` is low. Requests presented while `busy` is high are ignored and produce no result.
- R9: The index is unsigned: an index of 8'h80 or above adds 128 to 255 and never subtracts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `busy` is low |
| mode | input | 1 | 0 = zero-page indexed, 1 = absolute indexed |
| is_wr | input | 1 | 1 = the access is a write |
| base_addr | input | 16 | Base address; only bits 7:0 are used in zero-page mode |
| index | input | 8 | Unsigned index value |
| busy | output | 1 | High while a request is in progress |
| ea_valid | output | 1 | One-cycle strobe marking the final address |
| ea | output | 16 | Effective address, meaningful while `ea_valid` is high |
| fix_cycle | output | 1 | High in the extra high-byte fix-up cycle |

## Verification
The inputs are chosen to separate the one-cycle paths from the two-cycle paths. Absolute reads without a carry and with a carry show whether the penalty depends on the carry alone. Absolute writes without a carry show whether writes always pay the penalty. Zero-page reads and writes, with a non-zero high byte and a sum past 255, show whether the sum wraps in page zero and the high byte is left out. A base of FFF0 shows the 16-bit wrap, indexes of 80 and FF show unsigned treatment, and a request held high across a two-cycle access shows whether busy requests are dropped.

// File: rtl/idx_agu_pkg.sv
package idx_agu_pkg;

    typedef enum logic {
        AM_ZPG = 1'b0,
        AM_ABS = 1'b1
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_FIX  = 2'd2
    } st_e;

    // A second adder pass is needed for absolute mode when the low sum
    // carried, and always for an absolute write.
    function automatic logic fixup_needed(input am_e m, input logic wr, input logic carry);
        return (m == AM_ABS) && (wr || carry);
    endfunction

endpackage

// File: rtl/idx_agu_add.sv
module idx_agu_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/idx_agu_seq.sv
module idx_agu_seq
    import idx_agu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic need_fix,
    output st_e  state,
    output logic accept,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (req) state <= ST_LOW;
                ST_LOW:  state <= need_fix ? ST_FIX : ST_IDLE;
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign accept = (state == ST_IDLE) && req;
    assign busy   = (state != ST_IDLE);

    // R3: the fix-up cycle only ever follows a low-byte cycle that asked for it
    p_fix_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |-> ($past(state) == ST_LOW && $past(need_fix)));

    // R8: no new request can start while the previous one is in flight
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state != ST_LOW));
endmodule

// File: rtl/idx_agu.sv
module idx_agu
    import idx_agu_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              mode,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [BYTE_W-1:0] index,
    output logic              busy,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              fix_cycle
);
    st_e               state;
    logic              accept;
    logic              need_fix;

    logic [ADDR_W-1:0] base_q;
    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] low_q;
    am_e               mode_q;
    logic              wr_q;
    logic              carry_q;

    logic [BYTE_W-1:0] add_a;
    logic [BYTE_W-1:0] add_b;
    logic              add_ci;
    logic [BYTE_W-1:0] add_sum;
    logic              add_co;

    // One byte adder, shared between the low-byte pass and the high-byte fix-up
    always_comb begin
        if (state == ST_FIX) begin
            add_a  = base_q[ADDR_W-1:BYTE_W];
            add_b  = '0;
            add_ci = carry_q;
        end else begin
            add_a  = base_q[BYTE_W-1:0];
            add_b  = idx_q;
            add_ci = 1'b0;
        end
    end

    idx_agu_add #(.W(BYTE_W)) u_add (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_ci),
        .sum  (add_sum),
        .cout (add_co)
    );

    assign need_fix = (state == ST_LOW) && fixup_needed(mode_q, wr_q, add_co);

    idx_agu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .need_fix (need_fix),
        .state    (state),
        .accept   (accept),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            idx_q   <= '0;
            low_q   <= '0;
            mode_q  <= AM_ZPG;
            wr_q    <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            if (accept) begin
                base_q <= base_addr;
                idx_q  <= index;
                mode_q <= am_e'(mode);
                wr_q   <= is_wr;
            end
            if (state == ST_LOW) begin
                low_q   <= add_sum;
                carry_q <= add_co;
            end
        end
    end

    always_comb begin
        ea_valid  = 1'b0;
        fix_cycle = 1'b0;
        ea        = '0;
        case (state)
            ST_LOW: begin
                if (!need_fix) begin
                    ea_valid = 1'b1;
                    if (mode_q == AM_ZPG)
                        ea = {{BYTE_W{1'b0}}, add_sum};
                    else
                        ea = {base_q[ADDR_W-1:BYTE_W], add_sum};
                end
            end
            ST_FIX: begin
                ea_valid  = 1'b1;
                fix_cycle = 1'b1;
                ea        = {add_sum, low_q};
            end
            default: ;
        endcase
    end

    // R1: reset leaves every strobe low in the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ea_valid && !fix_cycle && !busy));

    // R7: the result strobe never lasts more than one cycle
    p_single_valid_r7: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    // R7: the penalty marker only accompanies a final address
    p_fix_has_valid_r7: assert property (@(posedge clk) disable iff (rst)
        fix_cycle |-> ea_valid);

    // R4: zero-page results stay in page zero
    p_zp_page_r4: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == AM_ZPG) |-> (ea[ADDR_W-1:BYTE_W] == '0));

    // R4: zero-page results never take the penalty
    p_zp_nofix_r4: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == AM_ZPG) |-> !fix_cycle);

    // R5: absolute writes always finish through the fix-up cycle
    p_write_fix_r5: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode_q == AM_ABS && wr_q) |-> fix_cycle);

    // R3: the low byte computed in the first pass survives into the fix-up cycle
    p_low_kept_r3: assert property (@(posedge clk) disable iff (rst)
        fix_cycle |-> (ea[BYTE_W-1:0] == $past(add_sum)));
endmodule

// File: tb/test_idx_agu.sv
`timescale 1ns/100ps
module test_idx_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        mode = 1'b0;
    logic        is_wr = 1'b0;
    logic [15:0] base_addr = '0;
    logic [7:0]  index = '0;
    logic        busy;
    logic        ea_valid;
    logic [15:0] ea;
    logic        fix_cycle;

    int    checks = 0;
    int    errors = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    int    vcount = 0;

    // reference model state
    int m_stage = 0;
    int m_ea = 0;
    bit m_pen = 1'b0;

    always #2.5 clk = ~clk;

    idx_agu i_idx_agu (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .mode      (mode),
        .is_wr     (is_wr),
        .base_addr (base_addr),
        .index     (index),
        .busy      (busy),
        .ea_valid  (ea_valid),
        .ea        (ea),
        .fix_cycle (fix_cycle)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: a countdown of the cycles left in the current access
    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0;
        end else if (m_stage > 0) begin
            m_stage = m_stage - 1;
        end else if (req) begin
            int lo_sum;
            lo_sum = int'(base_addr[7:0]) + int'(index);
            if (mode == 1'b0) begin
                m_ea  = lo_sum % 256;
                m_pen = 1'b0;
            end else begin
                m_ea  = (int'(base_addr) + int'(index)) % 65536;
                m_pen = is_wr || (lo_sum > 255);
            end
            m_stage = m_pen ? 2 : 1;
        end
    end

    // Comparison away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            bit ev;
            ev = (m_stage == 1);
            chk(ea_valid === ev, cur_tag, "ea_valid", int'(ea_valid), int'(ev));
            chk(fix_cycle === (ev && m_pen), cur_tag, "fix_cycle", int'(fix_cycle), int'(ev && m_pen));
            chk(busy === (m_stage > 0), cur_tag, "busy", int'(busy), int'(m_stage > 0));
            if (ev) begin
                chk(ea === 16'(m_ea), cur_tag, "ea", int'(ea), m_ea);
                vcount++;
            end
        end
    end

    task automatic send(input string tag, input bit md, input bit wr,
                        input logic [15:0] b, input logic [7:0] ix);
        @(negedge clk);
        cur_tag   = tag;
        vcount    = 0;
        req       = 1'b1;
        mode      = md;
        is_wr     = wr;
        base_addr = b;
        index     = ix;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        // R7: one result strobe per request
        chk(vcount == 1, "R7", "valid pulses", vcount, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk);
        armed = 1'b1;
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        send("R2", 1'b1, 1'b0, 16'h1234, 8'h10);   // 1244, one cycle
        send("R2", 1'b1, 1'b0, 16'h2000, 8'h00);   // 2000
        send("R3", 1'b1, 1'b0, 16'h12F0, 8'h20);   // 1310 with penalty
        send("R3", 1'b1, 1'b0, 16'h10FF, 8'h01);   // 1100 with penalty
        send("R4", 1'b0, 1'b0, 16'hABF0, 8'h20);   // 0010, high byte ignored
        send("R4", 1'b0, 1'b1, 16'h7705, 8'h03);   // 0008, write still one cycle
        send("R5", 1'b1, 1'b1, 16'h3000, 8'h05);   // 3005 with penalty
        send("R5", 1'b1, 1'b1, 16'h30F0, 8'h20);   // 3110 with penalty
        send("R6", 1'b1, 1'b0, 16'hFFF0, 8'h20);   // 0010 after wrap
        send("R6", 1'b1, 1'b1, 16'hFFFF, 8'hFF);   // 00FE after wrap
        send("R9", 1'b1, 1'b0, 16'h4000, 8'h80);   // 4080
        send("R9", 1'b0, 1'b0, 16'h0090, 8'hFF);   // 008F

        // R8: request held across a two-cycle access; later values must be dropped
        @(negedge clk);
        cur_tag   = "R8";
        vcount    = 0;
        req       = 1'b1;
        mode      = 1'b1;
        is_wr     = 1'b1;
        base_addr = 16'h3000;
        index     = 8'h01;
        @(negedge clk);
        base_addr = 16'h5555;
        index     = 8'h02;
        @(negedge clk);
        base_addr = 16'h6666;
        index     = 8'h03;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        chk(vcount == 1, "R8", "valid pulses", vcount, 1);

        // R1: reset in the middle of an access clears it
        @(negedge clk);
        cur_tag   = "R1";
        req       = 1'b1;
        base_addr = 16'h12F0;
        index     = 8'h20;
        mode      = 1'b1;
        is_wr     = 1'b0;
        @(negedge clk);
        req = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule